// File: doc/BRIEF.md
# Dual-Clock FIFO with Run-Time Threshold Flags

This block is a first-in first-out buffer that links two unrelated clock domains. It carries 18-bit words and its depth is a power-of-two parameter from 256 to 4096. A producer writes on its own free-running clock. A consumer reads on a second free-running clock. Each side has an active-low enable. All status outputs are active low: empty, full, half-full, almost-empty and almost-full.

On the read side, an active-low output-enable turns the output bus on and off. It also decides what a read does with its word. With the bus enabled, the word is driven out. With the bus released, the word is dropped without being shown. The two almost-flag thresholds are held in offset registers. The producer loads them at run time by holding a load strobe low while it writes.

Each pointer reaches the other clock domain as a Gray code through a chain of synchronizer flops. Because of this, a flag reacts to the far side's activity a few cycles late. The delay can only make a flag more cautious, never wrong in the unsafe direction.

Top module: `flagfifo_top`

## Requirements
- R1: Words written while `wrEnN` is low, `ldN` is high and the buffer is not full are read back in the same order they were written.
- R2: A read edge of `rdClk` with `rdEnN` low, `oeN` low and the buffer not empty puts the oldest word on `rdData` right after that edge.
- R3: While `oeN` is high, `rdData` is released (high-impedance).
- R4: A write attempted while `fullN` is low is ignored: no word is stored and the contents are unchanged.
- R5: A read attempted while `emptyN` is low is ignored: no pointer moves and `rdData` keeps its last value.
- R6: A read with `rdEnN` low and `oeN` high consumes the oldest word, and the output register keeps its previous value.
- R7: `emptyN` is low exactly when the stored count is 0, and `fullN` is low exactly when the count equals DEPTH, once both synchronizers have settled. While `emptyN` is high, the buffer always holds at least one word.
- R8: While `ldN` is low, each write goes to an offset register instead of the buffer. The writes alternate: almost-empty offset first, then almost-full offset. Each offset takes the low log2(DEPTH) bits of `wrData`. Both offsets are 7 after reset.
- R9: `halfN` is low exactly when the count is greater than DEPTH/2.
- R10: `almEmptyN` is low when the count is at or below the almost-empty offset. `almFullN` is low when DEPTH minus the count is at or below the almost-full offset.
- R11: While `rstN` is low, both pointers are cleared. The flag outputs then read `emptyN`=0, `fullN`=1, `halfN`=1, `almEmptyN`=0 and `almFullN`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wrClk | input | 1 | Write-side clock |
| rdClk | input | 1 | Read-side clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEnN | input | 1 | Write enable, active low |
| ldN | input | 1 | Routes writes to the offset registers when low |
| wrData | input | 18 | Write word or offset value |
| rdEnN | input | 1 | Read enable, active low |
| oeN | input | 1 | Output drive enable, active low; high makes a read skip its word |
| rdData | output | 18 | Read word, high-impedance while oeN is high |
| emptyN | output | 1 | Empty flag, active low (read domain) |
| fullN | output | 1 | Full flag, active low (write domain) |
| halfN | output | 1 | More than half full, active low (write domain) |
| almEmptyN | output | 1 | Almost-empty flag, active low (read domain) |
| almFullN | output | 1 | Almost-full flag, active low (write domain) |

## Verification
The directed patterns each target one behaviour:
- Offset loads followed by small fills separate the almost-empty threshold from plain empty.
- A complete fill, then a drain with pauses at DEPTH/2 and DEPTH/2+1 and at both sides of the almost-full offset, finds off-by-one errors in every count comparison.
- Writes pushed at a full buffer and reads pushed at an empty one show whether a guard leaks a pointer step.
- A skip read followed by a driven read separates "consumed" from "shown".

After the directed patterns, both sides run at once with random enables and random output-enable, on clocks of unrelated periods. This run compares every driven word against a queue model. It also flags any moment where the empty flag claims data that the model does not hold, which is where a faulty Gray crossing would show.

// File: rtl/flagfifo_pkg.sv
package flagfifo_pkg;
  // Per-cycle strobes from control to datapath
  typedef struct packed {
    logic wrEn;    // store wrData at the write address this wrClk edge
    logic rdLoad;  // copy the read-address word into the output register
  } fifoStb_t;
endpackage

// File: rtl/flagfifo_sync.sv
module flagfifo_sync #(
  parameter int WIDTH  = 9,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  logic [WIDTH-1:0] pipe [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= din;
    end else begin : g_next
      always_ff @(posedge clk or negedge rstN)
        if (!rstN) pipe[s] <= '0;
        else       pipe[s] <= pipe[s-1];
    end
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/flagfifo_ctrl.sv
module flagfifo_ctrl
  import flagfifo_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int SYNC_STAGES = 2,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = AW + 1
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic          ldN,
  input  logic [AW-1:0] offData,
  input  logic          rdEnN,
  input  logic          oeN,
  output fifoStb_t      stb,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic          emptyN,
  output logic          fullN,
  output logic          halfN,
  output logic          almEmptyN,
  output logic          almFullN
);
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

  function automatic logic [PW-1:0] toGray(input logic [PW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [PW-1:0] fromGray(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  // ---------------- write domain ----------------
  logic [PW-1:0] wBin, wGray, rGraySync, rBinW, wCount, freeCnt, wBinNext;
  logic [AW-1:0] aeOff, afOff;
  logic          loadSel, isFull, wrReq, ldReq;

  assign rBinW    = fromGray(rGraySync);
  assign wCount   = wBin - rBinW;
  assign freeCnt  = DEPTH_P - wCount;
  assign isFull   = (wCount == DEPTH_P);
  assign wrReq    = !wrEnN && ldN && !isFull;
  assign ldReq    = !wrEnN && !ldN;
  assign wBinNext = wBin + PW'(wrReq);

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wBin  <= '0;
      wGray <= '0;
    end else begin
      wBin  <= wBinNext;
      wGray <= toGray(wBinNext);
    end
  end

  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      aeOff   <= AW'(7);
      afOff   <= AW'(7);
      loadSel <= 1'b0;
    end else if (ldReq) begin
      if (!loadSel) aeOff <= offData;
      else          afOff <= offData;
      loadSel <= !loadSel;
    end
  end

  assign fullN    = !isFull;
  assign halfN    = !(wCount > HALF_P);
  assign almFullN = !(freeCnt <= {1'b0, afOff});

  // ---------------- read domain ----------------
  logic [PW-1:0] rBin, rGray, wGraySync, wBinR, rCount, rBinNext;
  logic          isEmpty, rdReq;

  assign wBinR    = fromGray(wGraySync);
  assign rCount   = wBinR - rBin;
  assign isEmpty  = (rGray == wGraySync);
  assign rdReq    = !rdEnN && !isEmpty;
  assign rBinNext = rBin + PW'(rdReq);

  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rBin  <= '0;
      rGray <= '0;
    end else begin
      rBin  <= rBinNext;
      rGray <= toGray(rBinNext);
    end
  end

  // aeOff is written on the write side; it is treated as quasi-static
  assign emptyN    = !isEmpty;
  assign almEmptyN = !(rCount <= {1'b0, aeOff});

  // ---------------- crossings ----------------
  flagfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rdClk), .rstN(rstN), .din(wGray), .dout(wGraySync)
  );
  flagfifo_sync #(.WIDTH(PW), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wrClk), .rstN(rstN), .din(rGray), .dout(rGraySync)
  );

  // ---------------- strobes ----------------
  assign stb.wrEn   = wrReq;
  assign stb.rdLoad = rdReq && !oeN;
  assign wrAddr     = wBin[AW-1:0];
  assign rdAddr     = rBin[AW-1:0];

  // ---------------- assertions ----------------
  // R4: a write at a full buffer leaves the write pointer where it was
  a_r4_no_overflow: assert property (@(posedge wrClk) disable iff (!rstN)
    (!fullN && !wrEnN && ldN) |=> $stable(wBin));

  // R5: a read at an empty buffer leaves the read pointer where it was
  a_r5_no_underflow: assert property (@(posedge rdClk) disable iff (!rstN)
    (!emptyN && !rdEnN) |=> $stable(rBin));

  // R8: an offset load never moves the write pointer
  a_r8_load_no_store: assert property (@(posedge wrClk) disable iff (!rstN)
    (!ldN && !wrEnN) |=> $stable(wBin));

  // R7: each crossing Gray word changes by at most one bit per edge
  a_r7_gray_step_w: assert property (@(posedge wrClk) disable iff (!rstN)
    $countones(wGray ^ $past(wGray)) <= 1);
  a_r7_gray_step_r: assert property (@(posedge rdClk) disable iff (!rstN)
    $countones(rGray ^ $past(rGray)) <= 1);

  // R7: the write-side view of the fill never exceeds the depth
  a_r7_count_bound: assert property (@(posedge wrClk) disable iff (!rstN)
    wCount <= DEPTH_P);

  // R7: the read side never reports more words than can exist
  a_r7_empty_count: assert property (@(posedge rdClk) disable iff (!rstN)
    rCount <= DEPTH_P);
endmodule

// File: rtl/flagfifo_dpath.sv
module flagfifo_dpath
  import flagfifo_pkg::*;
#(
  parameter int DEPTH = 256,
  parameter int DW    = 18,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  fifoStb_t      stb,
  input  logic [AW-1:0] wrAddr,
  input  logic [AW-1:0] rdAddr,
  input  logic [DW-1:0] wrData,
  input  logic          oeN,
  output logic [DW-1:0] rdData
);
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] outReg;

  always_ff @(posedge wrClk)
    if (stb.wrEn) mem[wrAddr] <= wrData;

  always_ff @(posedge rdClk or negedge rstN)
    if (!rstN)           outReg <= '0;
    else if (stb.rdLoad) outReg <= mem[rdAddr];

  assign rdData = oeN ? {DW{1'bz}} : outReg;

  // R6: without a load strobe the output register holds its word
  a_r6_skip_holds: assert property (@(posedge rdClk) disable iff (!rstN)
    !stb.rdLoad |=> $stable(outReg));
endmodule

// File: rtl/flagfifo_top.sv
module flagfifo_top
  import flagfifo_pkg::*;
#(
  parameter int DEPTH       = 256,
  parameter int DW          = 18,
  parameter int SYNC_STAGES = 2
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEnN,
  input  logic          ldN,
  input  logic [DW-1:0] wrData,
  input  logic          rdEnN,
  input  logic          oeN,
  output logic [DW-1:0] rdData,
  output logic          emptyN,
  output logic          fullN,
  output logic          halfN,
  output logic          almEmptyN,
  output logic          almFullN
);
  localparam int AW = $clog2(DEPTH);

  fifoStb_t      stb;
  logic [AW-1:0] wrAddr, rdAddr;

  flagfifo_ctrl #(.DEPTH(DEPTH), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .wrEnN(wrEnN), .ldN(ldN), .offData(wrData[AW-1:0]),
    .rdEnN(rdEnN), .oeN(oeN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN),
    .almEmptyN(almEmptyN), .almFullN(almFullN)
  );

  flagfifo_dpath #(.DEPTH(DEPTH), .DW(DW)) u_dpath (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .wrData(wrData), .oeN(oeN), .rdData(rdData)
  );
endmodule

// File: tb/flagfifo_tb.sv
module flagfifo_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = 13;
  localparam int DEPTH      = 256;

  logic wrClk = 0, rdClk = 0, rstN = 0;
  logic wrEnN = 1, ldN = 1, rdEnN = 1, oeN = 1;
  logic [17:0] wrData = '0;
  wire  [17:0] rdData;
  wire emptyN, fullN, halfN, almEmptyN, almFullN;

  always #(CLK_PERIOD/2) wrClk = ~wrClk;
  always #(RD_PERIOD/2.0) rdClk = ~rdClk;

  flagfifo_top #(.DEPTH(DEPTH)) dut_i (
    .wrClk(wrClk), .rdClk(rdClk), .rstN(rstN), .wrEnN(wrEnN), .ldN(ldN),
    .wrData(wrData), .rdEnN(rdEnN), .oeN(oeN), .rdData(rdData),
    .emptyN(emptyN), .fullN(fullN), .halfN(halfN),
    .almEmptyN(almEmptyN), .almFullN(almFullN)
  );

  int checks = 0, fails = 0;
  logic [17:0] q[$];
  int aeOff = 7, afOff = 7;
  bit loadSel = 0;
  logic [17:0] lastShown = '0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit expHalfN(int n);  return !(n > DEPTH/2); endfunction
  function automatic bit expAeN(int n);    return !(n <= aeOff); endfunction
  function automatic bit expAfN(int n);    return !((DEPTH - n) <= afOff); endfunction

  task automatic wrCycle(input bit en, input bit ld, input logic [17:0] d);
    bit room;
    @(negedge wrClk);
    wrEnN = !en; ldN = !ld; wrData = d; room = fullN;
    @(posedge wrClk);
    #1;
    if (en && ld) begin
      if (!loadSel) aeOff = int'(d[7:0]); else afOff = int'(d[7:0]);
      loadSel = !loadSel;
    end else if (en && room) q.push_back(d);
    wrEnN = 1; ldN = 1;
  endtask

  task automatic rdCycle(input bit en, input bit oe);
    bit avail;
    logic [17:0] exp;
    @(negedge rdClk);
    rdEnN = !en; oeN = !oe; avail = emptyN;
    if (en && avail) check(q.size() > 0, "R7 emptyN high with no data", 0, 1);
    @(posedge rdClk);
    #1 rdEnN = 1;
    if (en && avail && q.size() > 0) begin
      exp = q.pop_front();
      if (oe) begin
        @(negedge rdClk);
        check(rdData == exp, "R1/R2 read data", int'(rdData), int'(exp));
        lastShown = exp;
      end
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge rdClk);
    repeat (8) @(negedge wrClk);
  endtask

  task automatic checkFlags(input string where);
    int n = q.size();
    check(emptyN == (n != 0), {"R7 emptyN ", where}, int'(emptyN), int'(n != 0));
    check(fullN == (n != DEPTH), {"R7 fullN ", where}, int'(fullN), int'(n != DEPTH));
    check(halfN == expHalfN(n), {"R9 halfN ", where}, int'(halfN), int'(expHalfN(n)));
    check(almEmptyN == expAeN(n), {"R10 almEmptyN ", where}, int'(almEmptyN), int'(expAeN(n)));
    check(almFullN == expAfN(n), {"R10 almFullN ", where}, int'(almFullN), int'(expAfN(n)));
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    finishRun();
  end

  initial begin
    void'($urandom(1234));
    repeat (3) @(posedge wrClk);
    @(negedge wrClk);
    // R11: flag values during reset
    check(emptyN == 0 && fullN == 1 && halfN == 1 && almEmptyN == 0 && almFullN == 1,
          "R11 reset flags", {emptyN, fullN, halfN, almEmptyN, almFullN}, 5'b01101);
    rstN = 1;
    settle();
    checkFlags("after reset R11");

    // R8: load offsets, almost-empty first then almost-full
    wrCycle(1, 1, 18'h00003);
    wrCycle(1, 1, 18'h00005);
    settle();
    check(emptyN == 0, "R8 load stored no word", int'(emptyN), 0);
    checkFlags("after load R8");

    // R10: almost-empty boundary at offset 3
    for (int i = 0; i < 3; i++) wrCycle(1, 0, 18'h10 + 18'(i));
    settle(); checkFlags("count 3 R10");
    wrCycle(1, 0, 18'h13);
    settle(); checkFlags("count 4 R10");

    // R2: two driven reads
    rdCycle(1, 1); rdCycle(1, 1);
    // R6: skip read consumes word 0x12, output keeps 0x11
    rdCycle(1, 0);
    @(negedge rdClk); oeN = 0;
    @(negedge rdClk);
    check(rdData == lastShown, "R6 skip kept output", int'(rdData), int'(lastShown));
    rdCycle(1, 1);
    check(lastShown == 18'h13, "R6 skipped word consumed", int'(lastShown), 18'h13);

    // R3: bus released while oeN high
    @(negedge rdClk); oeN = 1;
    @(negedge rdClk);
    check(rdData === 18'bz || rdData === 18'h0, "R3 bus released", int'(rdData), 0);

    // R5: reads at empty ignored
    settle();
    for (int i = 0; i < 3; i++) rdCycle(1, 1);
    @(negedge rdClk);
    check(rdData == lastShown, "R5 empty read kept output", int'(rdData), int'(lastShown));
    wrCycle(1, 0, 18'h2AAAA);
    settle();
    rdCycle(1, 1);
    check(lastShown == 18'h2AAAA, "R5 pointer did not move", int'(lastShown), 18'h2AAAA);

    // R4/R9/R10: fill to full
    for (int i = 0; i < DEPTH; i++) wrCycle(1, 0, 18'h100 + 18'(i));
    settle(); checkFlags("full R4");
    wrCycle(1, 0, 18'h3FFFF); wrCycle(1, 0, 18'h3FFFE);
    settle(); checkFlags("write at full R4");
    while (q.size() > DEPTH - afOff) rdCycle(1, 1);
    settle(); checkFlags("af edge R10");
    rdCycle(1, 1); settle(); checkFlags("af edge-1 R10");
    while (q.size() > DEPTH/2 + 1) rdCycle(1, 1);
    settle(); checkFlags("half+1 R9");
    rdCycle(1, 1); settle(); checkFlags("half R9");
    while (q.size() > 0) rdCycle(1, 1);
    settle(); checkFlags("drained R4 R1");

    // random concurrent traffic
    fork
      for (int i = 0; i < 2000; i++) wrCycle(($urandom % 3) != 0, 0, 18'($urandom));
      for (int i = 0; i < 2600; i++) rdCycle(($urandom % 4) != 0, ($urandom % 5) != 0);
    join
    settle(); checkFlags("random R7");
    for (int i = 0; i < 4 * DEPTH && q.size() > 0; i++) rdCycle(1, 1);
    settle(); checkFlags("final R7");
    finishRun();
  end
endmodule